// File: doc/BRIEF.md
# Write-Once Fuse Array Controller

This block models a one-time-programmable fuse array of 32-bit words. The array sits behind a small bank of 32-bit control registers on a simple request bus. Software loads a word address, a bit index and a data-in value. It then writes the program-enable register, which sets or clears that single fuse bit. A shadow map records every bit that has been programmed. A second program of the same bit is refused: the fuse keeps its value, an error pulse is raised and a sticky violation flag is set.

Reading the data-out register returns the fuse word at the current address. This happens only while the chip-enable, data-strobe and trim enables are all set; otherwise the read returns zero. After reset every fuse reads as all ones, except two words. A configured serial number is preloaded at a fixed word, and its bitwise complement at the next word. The remaining test and timing registers are plain storage that reads back. Each bus access takes one cycle, and read data returns one cycle after the request.

Top module: `fuse_wo_ctrl`

## Requirements
- R1: After reset, every fuse word other than the two serial words reads 0xFFFFFFFF through data-out, and the status register (offset 0x3C, bit 0) reads 0.
- R2: The address register (offset 0x00) stores only the low 12 bits of the written value, and reads back that masked value.
- R3: A read of data-out (offset 0x10) returns the fuse word at the current address only when bit 0 is set in all three of chip enable (0x14), data strobe (0x18) and trim (0x1C). Otherwise it returns 0.
- R4: A write to the program-enable register (0x0C) with bit 0 set, while redundancy select (0x20) is zero, programs one fuse bit. The bit is selected by bits [4:0] of the bit-index register (0x04) in the addressed word. It becomes 1 if data-in (0x08) is nonzero, and 0 otherwise. A write with bit 0 clear programs nothing. Register 0x0C reads back the latched bit 0.
- R5: While redundancy select (0x20) is nonzero, a program-enable write changes no fuse and does not mark the bit as written, so the bit can be programmed afterwards.
- R6: A program of a bit already programmed since reset is refused. The fuse word is unchanged, and the err output is high in the cycle after the request.
- R7: Reset preloads the parameter SERIAL (default 0x12345678) at word SERIAL_WORD (default 0x0FC), and ~SERIAL at word SERIAL_WORD+1. Programming a bit of these words alters the preloaded value.
- R8: The registers at 0x04, 0x08 and 0x14 through 0x38 read back the full 32-bit value last written. Writes to 0x10 and 0x3C have no effect.
- R9: An access whose offset has either of the two low bits set, or is 0x40 or above, reads 0 and changes no register. The err output is high in the cycle after it.
- R10: rvalid is high exactly in the cycle after each read request, with rdata valid in that cycle. A write request produces no rvalid.
- R11: The violation flag (wo_sticky output and bit 0 of 0x3C) sets on a refused program and stays set until reset. Reset also returns all fuses to their preload values and clears the written map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Bus access request, one access per asserted cycle |
| wr | input | 1 | 1 for write, 0 for read |
| ofs | input | 8 | Byte offset into the register window |
| wdata | input | 32 | Write data |
| rvalid | output | 1 | Read data valid, one cycle after a read request |
| rdata | output | 32 | Read data |
| err | output | 1 | One-cycle pulse for an unmapped access or a refused program |
| wo_sticky | output | 1 | Sticky write-once violation flag |

## Verification
On every cycle the assertions check several things. They check the one-cycle read latency and the absence of responses to writes. They check that data-out reads zero while the enables are incomplete, and that unmapped accesses answer zero with an error. They also check that a successful program leaves the chosen bit at the data-in value, that a refused program leaves the word untouched, and that the violation flag never drops outside reset. Other properties need a history of accesses, and only the directed scenarios show them. These are the serial preload and its complement, and the masking of the address. They also include the redundancy select leaving a bit still programmable, the read-back of every plain register, and the restoration of all fuses by reset.

// File: rtl/wofc_pkg.sv
package wofc_pkg;

  localparam int NREG = 16;

  typedef enum logic [3:0] {
    RG_WADDR  = 4'd0,
    RG_BITSEL = 4'd1,
    RG_DIN    = 4'd2,
    RG_PGMEN  = 4'd3,
    RG_DOUT   = 4'd4,
    RG_CE     = 4'd5,
    RG_STROBE = 4'd6,
    RG_TRIM   = 4'd7,
    RG_REDUND = 4'd8,
    RG_CLK    = 4'd9,
    RG_PGM    = 4'd10,
    RG_TCTRL  = 4'd11,
    RG_TMODE  = 4'd12,
    RG_TREP   = 4'd13,
    RG_RTRIM  = 4'd14,
    RG_STATUS = 4'd15
  } reg_idx_e;

  function automatic logic is_plain(input logic [3:0] i);
    return !(i == RG_WADDR || i == RG_PGMEN || i == RG_DOUT || i == RG_STATUS);
  endfunction

endpackage

// File: rtl/wofc_word_ram.sv
module wofc_word_ram #(
  parameter int DEPTH = 4096,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // write-first single-clock RAM, registered read port
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (we && waddr == raddr) rdata <= wdata;
    else                      rdata <= mem[raddr];
  end

endmodule

// File: rtl/wofc_core.sv
module wofc_core #(
  parameter int          WORDS       = 4096,
  parameter int          DW          = 32,
  parameter logic [31:0] SERIAL      = 32'h1234_5678,
  parameter int          SERIAL_WORD = 252,
  localparam int         AW          = $clog2(WORDS),
  localparam int         BW          = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] pa,
  input  logic [AW-1:0] pa_next,
  input  logic [BW-1:0] bitsel,
  input  logic          din_bit,
  input  logic          fire,
  output logic [DW-1:0] fuse_word,
  output logic          viol
);

  localparam logic [AW-1:0] SW_A = AW'(SERIAL_WORD);
  localparam logic [AW-1:0] SW_B = AW'(SERIAL_WORD + 1);

  logic [WORDS-1:0] touched;
  logic [DW-1:0]    map_q, val_q, wmap_eff, bit_mask, new_map, new_val, base;
  logic             prog_ok;

  wofc_word_ram #(.DEPTH(WORDS), .DW(DW)) u_map_ram (
    .clk(clk), .we(prog_ok), .waddr(pa), .wdata(new_map),
    .raddr(pa_next), .rdata(map_q)
  );

  wofc_word_ram #(.DEPTH(WORDS), .DW(DW)) u_val_ram (
    .clk(clk), .we(prog_ok), .waddr(pa), .wdata(new_val),
    .raddr(pa_next), .rdata(val_q)
  );

  always_comb begin
    wmap_eff = touched[pa] ? map_q : '0;
    bit_mask = DW'(1) << bitsel;
    viol     = fire &  wmap_eff[bitsel];
    prog_ok  = fire & ~wmap_eff[bitsel];
    new_map  = wmap_eff | bit_mask;
    new_val  = (val_q & wmap_eff & ~bit_mask) | (din_bit ? bit_mask : '0);
    if (pa == SW_A)      base = DW'(SERIAL);
    else if (pa == SW_B) base = ~DW'(SERIAL);
    else                 base = '1;
    fuse_word = (base & ~wmap_eff) | (val_q & wmap_eff);
  end

  always_ff @(posedge clk) begin
    if (rst)          touched <= '0;
    else if (prog_ok) touched[pa] <= 1'b1;
  end

  // R4: a successful program leaves the chosen bit at the data-in value
  p_prog_value_r4: assert property (@(posedge clk) disable iff (rst)
    prog_ok |=> fuse_word[$past(bitsel)] == $past(din_bit));

  // R6: a refused program leaves the word untouched
  p_refuse_keep_r6: assert property (@(posedge clk) disable iff (rst)
    viol |=> fuse_word == $past(fuse_word));

endmodule

// File: rtl/wofc_regs.sv
module wofc_regs
  import wofc_pkg::*;
#(
  parameter int  AW    = 12,
  parameter int  BW    = 5,
  parameter int  OFS_W = 8,
  localparam int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    fuse_word,
  input  logic             viol,
  output logic             rvalid,
  output logic [DW-1:0]    rdata,
  output logic             err,
  output logic             sticky,
  output logic [AW-1:0]    pa,
  output logic [AW-1:0]    pa_next,
  output logic [BW-1:0]    bitsel,
  output logic             din_bit,
  output logic             fire
);

  logic [DW-1:0] store [NREG];
  logic          we_bit;
  logic          mapped, wr_hit, rd_hit, gate;
  logic [3:0]    idx;
  logic [DW-1:0] rd_val;

  always_comb begin
    mapped  = ((ofs >> 6) == '0) && (ofs[1:0] == 2'b00);
    idx     = ofs[5:2];
    wr_hit  = req &  wr & mapped;
    rd_hit  = req & ~wr & mapped;
    gate    = store[RG_CE][0] & store[RG_STROBE][0] & store[RG_TRIM][0];
    pa_next = (wr_hit && idx == RG_WADDR) ? wdata[AW-1:0] : pa;
    bitsel  = store[RG_BITSEL][BW-1:0];
    din_bit = |store[RG_DIN];
    fire    = wr_hit && idx == RG_PGMEN && wdata[0] && store[RG_REDUND] == '0;
    case (idx)
      RG_WADDR:  rd_val = DW'(pa);
      RG_PGMEN:  rd_val = DW'(we_bit);
      RG_DOUT:   rd_val = gate ? fuse_word : '0;
      RG_STATUS: rd_val = DW'(sticky);
      default:   rd_val = store[idx];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) store[i] <= '0;
      pa     <= '0;
      we_bit <= 1'b0;
    end else begin
      for (int i = 0; i < NREG; i++)
        if (wr_hit && idx == 4'(i) && is_plain(4'(i))) store[i] <= wdata;
      pa <= pa_next;
      if (wr_hit && idx == RG_PGMEN) we_bit <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rdata  <= '0;
      err    <= 1'b0;
      sticky <= 1'b0;
    end else begin
      rvalid <= req & ~wr;
      rdata  <= rd_hit ? rd_val : '0;
      err    <= (req & ~mapped) | viol;
      sticky <= sticky | viol;
    end
  end

  // R10: read response exactly one cycle after a read request
  p_rvalid_lat_r10: assert property (@(posedge clk) disable iff (rst)
    (req && !wr) |=> rvalid);
  p_no_wr_resp_r10: assert property (@(posedge clk) disable iff (rst)
    !(req && !wr) |=> !rvalid);

  // R3: data-out reads zero unless all three enables are set
  p_dout_gate_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_hit && idx == RG_DOUT && !gate) |=> rdata == '0);

  // R9: unmapped access answers zero and raises err
  p_unmapped_r9: assert property (@(posedge clk) disable iff (rst)
    (req && !mapped) |=> (err && rdata == '0));

  // R11: violation flag never drops outside reset
  p_sticky_hold_r11: assert property (@(posedge clk) disable iff (rst)
    sticky |=> sticky);

endmodule

// File: rtl/fuse_wo_ctrl.sv
module fuse_wo_ctrl #(
  parameter int          WORDS       = 4096,
  parameter logic [31:0] SERIAL      = 32'h1234_5678,
  parameter int          SERIAL_WORD = 252,
  parameter int          OFS_W       = 8,
  localparam int         DW          = 32,
  localparam int         AW          = $clog2(WORDS),
  localparam int         BW          = $clog2(DW)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             wr,
  input  logic [OFS_W-1:0] ofs,
  input  logic [DW-1:0]    wdata,
  output logic             rvalid,
  output logic [DW-1:0]    rdata,
  output logic             err,
  output logic             wo_sticky
);

  logic [AW-1:0] pa, pa_next;
  logic [BW-1:0] bitsel;
  logic          din_bit, fire, viol;
  logic [DW-1:0] fuse_word;

  wofc_regs #(.AW(AW), .BW(BW), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .ofs(ofs), .wdata(wdata),
    .fuse_word(fuse_word), .viol(viol),
    .rvalid(rvalid), .rdata(rdata), .err(err), .sticky(wo_sticky),
    .pa(pa), .pa_next(pa_next), .bitsel(bitsel), .din_bit(din_bit),
    .fire(fire)
  );

  wofc_core #(.WORDS(WORDS), .DW(DW), .SERIAL(SERIAL),
              .SERIAL_WORD(SERIAL_WORD)) u_core (
    .clk(clk), .rst(rst), .pa(pa), .pa_next(pa_next), .bitsel(bitsel),
    .din_bit(din_bit), .fire(fire), .fuse_word(fuse_word), .viol(viol)
  );

endmodule

// File: tb/fuse_wo_ctrl_test.sv
`timescale 1ns/1ps
module fuse_wo_ctrl_test;

  localparam logic [7:0] O_WADDR = 8'h00, O_BITSEL = 8'h04, O_DIN = 8'h08,
    O_PGMEN = 8'h0C, O_DOUT = 8'h10, O_CE = 8'h14, O_STROBE = 8'h18,
    O_TRIM = 8'h1C, O_REDUND = 8'h20, O_CLK = 8'h24, O_TMODE = 8'h30,
    O_RTRIM = 8'h38, O_STATUS = 8'h3C;
  localparam logic [31:0] SER = 32'h1234_5678;
  localparam logic [31:0] SW  = 32'h0FC;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, wr = 1'b0;
  logic [7:0]  ofs = '0;
  logic [31:0] wdata = '0;
  logic        rvalid, err, wo_sticky;
  logic [31:0] rdata;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fuse_wo_ctrl uut (.clk(clk), .rst(rst), .req(req), .wr(wr), .ofs(ofs),
    .wdata(wdata), .rvalid(rvalid), .rdata(rdata), .err(err),
    .wo_sticky(wo_sticky));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] o, input logic [31:0] d, output logic e);
    @(negedge clk); req = 1; wr = 1; ofs = o; wdata = d;
    @(negedge clk); req = 0; wr = 0; e = err;
    chk("R10 no rvalid on write", 32'(rvalid), 32'd0);
  endtask

  task automatic rd_reg(input logic [7:0] o, output logic [31:0] d, output logic e);
    @(negedge clk); req = 1; wr = 0; ofs = o;
    @(negedge clk); req = 0; d = rdata; e = err;
    chk("R10 rvalid after read", 32'(rvalid), 32'd1);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1; repeat (3) @(negedge clk); rst = 0;
  endtask

  task automatic set_enables(input logic ce, input logic st, input logic tr);
    logic e;
    wr_reg(O_CE, 32'(ce), e); wr_reg(O_STROBE, 32'(st), e); wr_reg(O_TRIM, 32'(tr), e);
  endtask

  task automatic read_word(input logic [31:0] a, output logic [31:0] d);
    logic e;
    wr_reg(O_WADDR, a, e); rd_reg(O_DOUT, d, e);
  endtask

  task automatic prog(input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] din, output logic e);
    logic e0;
    wr_reg(O_WADDR, a, e0); wr_reg(O_BITSEL, b, e0); wr_reg(O_DIN, din, e0);
    wr_reg(O_PGMEN, 32'd1, e);
  endtask

  task automatic t_reset;
    logic [31:0] d; logic e;
    rd_reg(O_STATUS, d, e); chk("R1 status after reset", d, 0);
    chk("R11 sticky after reset", 32'(wo_sticky), 0);
    set_enables(1, 1, 1);
    read_word(32'h5, d);   chk("R1 blank word 5", d, 32'hFFFF_FFFF);
    read_word(32'hFFF, d); chk("R1 blank last word", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_serial;
    logic [31:0] d;
    read_word(SW, d);     chk("R7 serial word", d, SER);
    read_word(SW + 1, d); chk("R7 complement word", d, ~SER);
  endtask

  task automatic t_addr_mask;
    logic [31:0] d; logic e;
    wr_reg(O_WADDR, 32'hFFFF_F123, e);
    rd_reg(O_WADDR, d, e); chk("R2 address masked", d, 32'h123);
  endtask

  task automatic t_gate;
    logic [31:0] d; logic e;
    wr_reg(O_WADDR, SW, e);
    set_enables(1, 1, 0); rd_reg(O_DOUT, d, e); chk("R3 trim off", d, 0);
    set_enables(1, 0, 1); rd_reg(O_DOUT, d, e); chk("R3 strobe off", d, 0);
    set_enables(0, 1, 1); rd_reg(O_DOUT, d, e); chk("R3 chip enable off", d, 0);
    set_enables(1, 1, 1); rd_reg(O_DOUT, d, e); chk("R3 all enabled", d, SER);
  endtask

  task automatic t_program;
    logic [31:0] d; logic e;
    prog(32'h10, 3, 0, e); chk("R4 no err on first program", 32'(e), 0);
    read_word(32'h10, d);  chk("R4 clear bit 3", d, 32'hFFFF_FFF7);
    prog(32'h10, 7, 5, e); read_word(32'h10, d); chk("R4 set bit 7", d, 32'hFFFF_FFF7);
    rd_reg(O_PGMEN, d, e); chk("R4 enable readback", d, 1);
    wr_reg(O_BITSEL, 0, e); wr_reg(O_DIN, 0, e); wr_reg(O_PGMEN, 0, e);
    read_word(32'h10, d); chk("R4 bit0 clear writes nothing", d, 32'hFFFF_FFF7);
    rd_reg(O_PGMEN, d, e); chk("R4 enable readback zero", d, 0);
    prog(SW, 3, 0, e); read_word(SW, d); chk("R7 program serial word", d, 32'h1234_5670);
  endtask

  task automatic t_redund;
    logic [31:0] d; logic e;
    wr_reg(O_REDUND, 1, e);
    prog(32'h20, 0, 0, e); chk("R5 no err while redundant", 32'(e), 0);
    read_word(32'h20, d); chk("R5 no change while redundant", d, 32'hFFFF_FFFF);
    wr_reg(O_REDUND, 0, e);
    prog(32'h20, 0, 0, e); chk("R5 bit still programmable", 32'(e), 0);
    read_word(32'h20, d); chk("R5 program after redundancy", d, 32'hFFFF_FFFE);
  endtask

  task automatic t_second;
    logic [31:0] d; logic e;
    prog(32'h10, 3, 1, e); chk("R6 err on reprogram", 32'(e), 1);
    read_word(32'h10, d);  chk("R6 word unchanged", d, 32'hFFFF_FFF7);
    chk("R11 sticky set", 32'(wo_sticky), 1);
    prog(32'h10, 7, 0, e); chk("R6 err on reprogram bit 7", 32'(e), 1);
    read_word(32'h10, d);  chk("R6 bit 7 kept", d, 32'hFFFF_FFF7);
    repeat (5) @(negedge clk);
    rd_reg(O_STATUS, d, e); chk("R11 status held", d, 1);
  endtask

  task automatic t_plain;
    logic [31:0] d; logic e;
    wr_reg(O_CLK, 32'hA5A5_0001, e);   rd_reg(O_CLK, d, e);   chk("R8 clock reg", d, 32'hA5A5_0001);
    wr_reg(O_TMODE, 32'hDEAD_BEEF, e); rd_reg(O_TMODE, d, e); chk("R8 test mode reg", d, 32'hDEAD_BEEF);
    wr_reg(O_RTRIM, 32'h0F0F_F0F0, e); rd_reg(O_RTRIM, d, e); chk("R8 read trim reg", d, 32'h0F0F_F0F0);
    wr_reg(O_BITSEL, 32'h8000_0022, e); rd_reg(O_BITSEL, d, e); chk("R8 bit index full", d, 32'h8000_0022);
    wr_reg(O_WADDR, 32'h10, e); wr_reg(O_DOUT, 32'h0, e);
    rd_reg(O_DOUT, d, e); chk("R8 data-out write ignored", d, 32'hFFFF_FFF7);
    wr_reg(O_STATUS, 0, e); rd_reg(O_STATUS, d, e); chk("R8 status write ignored", d, 1);
  endtask

  task automatic t_unmapped;
    logic [31:0] d; logic e;
    rd_reg(8'h41, d, e); chk("R9 misaligned reads zero", d, 0); chk("R9 err misaligned", 32'(e), 1);
    rd_reg(8'h80, d, e); chk("R9 high offset zero", d, 0);      chk("R9 err high offset", 32'(e), 1);
    wr_reg(8'h01, 32'h55, e); chk("R9 err on write", 32'(e), 1);
    rd_reg(O_WADDR, d, e); chk("R9 write ignored", d, 32'h10);
    wr_reg(8'h44, 32'h77, e); rd_reg(O_WADDR, d, e); chk("R9 no alias write", d, 32'h10);
  endtask

  task automatic t_reset_again;
    logic [31:0] d; logic e;
    do_reset;
    chk("R11 sticky cleared by reset", 32'(wo_sticky), 0);
    set_enables(1, 1, 1);
    read_word(32'h10, d); chk("R11 fuses restored", d, 32'hFFFF_FFFF);
    read_word(SW, d);     chk("R11 serial restored", d, SER);
    prog(32'h10, 3, 0, e); chk("R11 map cleared", 32'(e), 0);
  endtask

  task automatic report;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset; t_serial; t_addr_mask; t_gate; t_program;
    t_redund; t_second; t_plain; t_unmapped; t_reset_again;
    done = 1;
    report;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      report;
      $finish;
    end
  end

endmodule